// File: doc/BRIEF.md
# General-Purpose I/O Port with Stop-Mode Pin Retention

This block is an 8-bit general-purpose I/O port for a small microcontroller. Software reaches it over a simple register bus with a 2-bit address, a write strobe and combinational read data. The bus exposes a data latch, a direction register, a pull-up enable register and a power status/acknowledge register. Each pin has three pad controls: output enable, output value and pull-up enable. Pin levels pass through a short synchroniser before software can read them. Two pins differ from the rest. One of them always reads back its pin level, and another always reads back its stored latch value, whatever their direction bits hold.

A 2-bit power-mode input sets the port's behaviour in stop.
- **Deep stop** wipes every register. All pins return to their reset defaults.
- **Light stop** keeps everything exactly as it was.
- **Partial-power-down stop** clears the registers but freezes the pads at the state they had when stop began. A status flag then tells software that the registers were lost. The pads stay frozen until software writes the acknowledge bit, so software can rebuild the registers first and release the pins afterwards without a glitch.

Top module: `gpio_ret_port`

## Requirements
- R1: After reset, the data, direction and pull-up registers read 0, all pad controls are 0 and the power status register reads 0.
- R2: A write with `bus_we`=1 in run mode updates the addressed register on the next rising clock edge. Address 1 (direction) and address 2 (pull-up) read back the stored value.
- R3: Reading address 0 returns, for each ordinary bit, the synchronised pin level when its direction bit is 0 and the data latch when its direction bit is 1. Each pin level passes through SYNC_STAGES (default 2) flops.
- R4: Bit 5 of address 0 always returns the synchronised pin level, regardless of its direction bit.
- R5: Bit 4 of address 0 always returns the data latch, regardless of its direction bit.
- R6: Outside a hold, `pad_oe` equals the direction register and `pad_out` equals the data latch. `pad_pu` is 1 only where the pull-up bit is 1 and the direction bit is 0.
- R7: In power mode 1 (deep stop), all registers and the power flag are cleared. After return to run mode (mode 0), all pad controls are 0.
- R8: In power mode 2 (partial-power-down stop), the registers are cleared but the pads keep the state they had just before entry. They stay held after return to run mode until acknowledge, even if registers are rewritten.
- R9: After a mode-2 stop, bit 0 of address 3 reads 1. Writing 1 to bit 1 of address 3 clears the flag and releases the pads to follow the registers. Bit 1 always reads 0.
- R10: In power mode 3 (light stop), all registers and pad controls are retained unchanged.
- R11: Bus writes are ignored in every mode other than run (mode 0).
- R12: Writing the acknowledge bit while the flag is 0 changes neither the pads nor the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pmode | input | 2 | Power mode: 0 run, 1 deep stop, 2 partial-power-down stop, 3 light stop |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 pull-up, 3 power status/acknowledge |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 8 | Pin levels from the pads |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The hardest situation to reach is the window after a partial-power-down wake in which the pads are still frozen while the registers already hold different values. Only in that window can a hold that releases too early be seen at the ports. The stimulus programs a distinctive drive pattern and enters mode 2 for several cycles, then returns to run. While the flag is still set, it rewrites the data latch to a new value. It checks that the pads still show the old pattern, and only then writes the acknowledge bit and checks that the pads switch to the new register contents.

// File: rtl/gpio_ret_pkg.sv
package gpio_ret_pkg;

    localparam int PORT_W       = 8;
    localparam int PWR_FLAG_BIT = 0;
    localparam int PWR_ACK_BIT  = 1;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_DEEP  = 2'd1,
        PM_PPD   = 2'd2,
        PM_LIGHT = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {
        RA_DATA = 2'd0,
        RA_DIR  = 2'd1,
        RA_PULL = 2'd2,
        RA_PWR  = 2'd3
    } regaddr_e;

    typedef logic [PORT_W-1:0] port_vec_t;

    typedef struct packed {
        port_vec_t dir;
        port_vec_t data;
        port_vec_t pull;
    } port_regs_t;

    typedef struct packed {
        port_vec_t oe;
        port_vec_t out;
        port_vec_t pu;
    } pad_ctrl_t;

    function automatic pad_ctrl_t pads_from_regs(port_regs_t r);
        pad_ctrl_t p;
        p.oe  = r.dir;
        p.out = r.data;
        p.pu  = r.pull & ~r.dir;
        return p;
    endfunction

    function automatic port_vec_t data_readback(port_regs_t r, port_vec_t pins,
                                                int unsigned in_only,
                                                int unsigned out_only);
        port_vec_t v;
        v = (pins & ~r.dir) | (r.data & r.dir);
        v[in_only]  = pins[in_only];
        v[out_only] = r.data[out_only];
        return v;
    endfunction

endpackage

// File: rtl/gpio_ret_sync.sv
module gpio_ret_sync
    import gpio_ret_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  port_vec_t pin_raw,
    output port_vec_t pin_sync
);

    localparam int LAST = SYNC_STAGES - 1;

    port_vec_t stage_q [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= pin_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign pin_sync = stage_q[LAST];

endmodule

// File: rtl/gpio_ret_regs.sv
module gpio_ret_regs
    import gpio_ret_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pmode_e     pmode,
    input  logic       we,
    input  regaddr_e   addr,
    input  port_vec_t  wdata,
    output port_regs_t regs_q,
    output logic       ppd_flag_q,
    output logic       ack_pulse
);

    logic wr_ok;
    logic wipe;

    assign wr_ok     = we && (pmode == PM_RUN);
    assign wipe      = (pmode == PM_DEEP) || (pmode == PM_PPD);
    assign ack_pulse = wr_ok && (addr == RA_PWR) && wdata[PWR_ACK_BIT];

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            regs_q <= '0;
        end else if (wr_ok) begin
            case (addr)
                RA_DATA: regs_q.data <= wdata;
                RA_DIR:  regs_q.dir  <= wdata;
                RA_PULL: regs_q.pull <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pmode == PM_DEEP) ppd_flag_q <= 1'b0;
        else if (pmode == PM_PPD)    ppd_flag_q <= 1'b1;
        else if (ack_pulse)          ppd_flag_q <= 1'b0;
    end

    AST_DEEP_WIPES: assert property (@(posedge clk) disable iff (rst)
        (pmode == PM_DEEP) |=> (regs_q == '0 && !ppd_flag_q)); // R7
    AST_LIGHT_RETAINS: assert property (@(posedge clk) disable iff (rst)
        (pmode == PM_LIGHT) |=> $stable(regs_q)); // R10
    AST_STOP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (pmode != PM_RUN && !wipe) |=> $stable(regs_q)); // R11
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (pmode == PM_PPD) |=> ppd_flag_q); // R9

endmodule

// File: rtl/gpio_ret_hold.sv
module gpio_ret_hold
    import gpio_ret_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pmode_e    pmode,
    input  logic      ack,
    input  pad_ctrl_t live,
    output pad_ctrl_t pads,
    output logic      hold_act
);

    pad_ctrl_t frozen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frozen_q <= '0;
            hold_act <= 1'b0;
        end else begin
            if (!hold_act) frozen_q <= live;
            if (pmode == PM_DEEP)      hold_act <= 1'b0;
            else if (pmode == PM_PPD)  hold_act <= 1'b1;
            else if (ack)              hold_act <= 1'b0;
        end
    end

    assign pads = hold_act ? frozen_q : live;

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (hold_act && pmode != PM_DEEP && !(pmode == PM_RUN && ack)) |=> $stable(pads)); // R8
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (ack && pmode == PM_RUN) |=> !hold_act); // R9

endmodule

// File: rtl/gpio_ret_port.sv
module gpio_ret_port
    import gpio_ret_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IN_ONLY_BIT = 5,
    parameter int OUT_ONLY_BIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pmode,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pu
);

    pmode_e     mode;
    regaddr_e   addr;
    port_regs_t regs;
    port_vec_t  pin_s;
    logic       ppd_flag;
    logic       ack;
    logic       hold_act;
    pad_ctrl_t  live;
    pad_ctrl_t  pads;

    assign mode = pmode_e'(pmode);
    assign addr = regaddr_e'(bus_addr);

    gpio_ret_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_raw  (pin_in),
        .pin_sync (pin_s)
    );

    gpio_ret_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .pmode      (mode),
        .we         (bus_we),
        .addr       (addr),
        .wdata      (bus_wdata),
        .regs_q     (regs),
        .ppd_flag_q (ppd_flag),
        .ack_pulse  (ack)
    );

    assign live = pads_from_regs(regs);

    gpio_ret_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .pmode    (mode),
        .ack      (ack),
        .live     (live),
        .pads     (pads),
        .hold_act (hold_act)
    );

    assign pad_oe  = pads.oe;
    assign pad_out = pads.out;
    assign pad_pu  = pads.pu;

    always_comb begin
        bus_rdata = '0;
        case (addr)
            RA_DATA: bus_rdata = data_readback(regs, pin_s, IN_ONLY_BIT, OUT_ONLY_BIT);
            RA_DIR:  bus_rdata = regs.dir;
            RA_PULL: bus_rdata = regs.pull;
            RA_PWR:  bus_rdata[PWR_FLAG_BIT] = ppd_flag;
            default: bus_rdata = '0;
        endcase
    end

    AST_PU_INPUT_ONLY: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_oe) == '0); // R6
    AST_HOLD_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_RUN && hold_act) |-> ppd_flag); // R8

endmodule

// File: tb/sim_gpio_ret_port.sv
module sim_gpio_ret_port;

    localparam int W = 8;
    localparam int NVEC = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   pmode = 2'd0;
    logic [1:0]   bus_addr = 2'd0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_pu;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_ret_port u0 (
        .clk(clk), .rst(rst), .pmode(pmode), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    // {dir, data, pin, expected data readback}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h00_FF_A5_B5,
        32'hFF_3C_C3_1C,
        32'h0F_5A_F0_FA,
        32'h30_00_FF_EF,
        32'h00_10_00_10,
        32'hCF_00_20_20
    };

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic stay_mode(logic [1:0] m, int n);
        @(negedge clk);
        pmode = m;
        repeat (n) @(negedge clk);
        pmode = 2'd0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd1, r); check("R1 dir", r, 8'h00);
        rd(2'd2, r); check("R1 pull", r, 8'h00);
        rd(2'd3, r); check("R1 status", r, 8'h00);
        check("R1 oe", pad_oe, 8'h00);
        check("R1 out", pad_out, 8'h00);
        check("R1 pu", pad_pu, 8'h00);

        // R2 R3 R4 R5 R6 table walk
        for (int i = 0; i < NVEC; i++) begin
            pin_in = VEC[i][15:8];
            wr(2'd1, VEC[i][31:24]);
            wr(2'd0, VEC[i][23:16]);
            wr(2'd2, 8'hFF);
            repeat (3) @(negedge clk);
            rd(2'd0, r); check("R3/R4/R5 data read", r, VEC[i][7:0]);
            rd(2'd1, r); check("R2 dir readback", r, VEC[i][31:24]);
            check("R6 oe", pad_oe, VEC[i][31:24]);
            check("R6 out", pad_out, VEC[i][23:16]);
            check("R6 pu", pad_pu, ~VEC[i][31:24]);
        end

        // R12 ack with flag clear: nothing changes (last vector state)
        wr(2'd3, 8'h02);
        rd(2'd3, r); check("R12 status", r, 8'h00);
        check("R12 oe", pad_oe, 8'hCF);
        check("R12 pu", pad_pu, 8'h30);

        // R8 R9 partial-power-down stop
        wr(2'd2, 8'h00);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hA5);
        stay_mode(2'd2, 4);
        check("R8 held oe in run", pad_oe, 8'hFF);
        check("R8 held out in run", pad_out, 8'hA5);
        rd(2'd1, r); check("R8 dir lost", r, 8'h00);
        rd(2'd3, r); check("R9 flag set", r, 8'h01);
        wr(2'd0, 8'h3C);
        wr(2'd1, 8'h0F);
        check("R8 still held out", pad_out, 8'hA5);
        check("R8 still held oe", pad_oe, 8'hFF);
        wr(2'd3, 8'h02);
        rd(2'd3, r); check("R9 flag cleared, ack reads 0", r, 8'h00);
        check("R9 released oe", pad_oe, 8'h0F);
        check("R9 released out", pad_out, 8'h3C);

        // R7 deep stop
        wr(2'd1, 8'hF0);
        wr(2'd0, 8'h77);
        wr(2'd2, 8'hFF);
        stay_mode(2'd1, 3);
        rd(2'd1, r); check("R7 dir", r, 8'h00);
        rd(2'd2, r); check("R7 pull", r, 8'h00);
        rd(2'd3, r); check("R7 status", r, 8'h00);
        check("R7 oe", pad_oe, 8'h00);
        check("R7 out", pad_out, 8'h00);
        check("R7 pu", pad_pu, 8'h00);

        // R10 R11 light stop with attempted writes
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'h5A);
        wr(2'd2, 8'hF0);
        @(negedge clk);
        pmode = 2'd3;
        bus_addr = 2'd1; bus_wdata = 8'h00; bus_we = 1'b1;
        @(negedge clk);
        bus_addr = 2'd0;
        @(negedge clk);
        bus_addr = 2'd2;
        @(negedge clk);
        bus_we = 1'b0;
        check("R10 oe during stop", pad_oe, 8'h0F);
        pmode = 2'd0;
        rd(2'd1, r); check("R11 dir unchanged", r, 8'h0F);
        rd(2'd2, r); check("R11 pull unchanged", r, 8'hF0);
        check("R10 out", pad_out, 8'h5A);
        check("R10 pu", pad_pu, 8'hF0);
        rd(2'd3, r); check("R10 status", r, 8'h00);

        // R11 writes ignored in deep stop do not reappear
        @(negedge clk);
        pmode = 2'd1;
        bus_addr = 2'd1; bus_wdata = 8'hAA; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; pmode = 2'd0;
        rd(2'd1, r); check("R11 deep stop write dropped", r, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule